// File: doc/BRIEF.md
# Double-Rate First-Order Recursive Smoother

This block is a single-pole recursive low-pass filter of the kind used to smooth a level estimate, for example inside a gain-tracking loop. For every accepted input sample it computes y[n] = a·x[n] + (1 − a)·y[n−1]. The coefficient a is unsigned with one integer bit and fifteen fraction bits. It is applied in the rearranged form y[n] = y[n−1] + a·(x[n] − y[n−1]).

The multiplier result and the adder result each sit in their own register, so the recursion loop is two registers long. The block therefore runs on a clock at twice the sample rate. It spends one fast cycle on the multiply and one on the accumulate. A new sample may arrive at most every second fast cycle, and the output stays sample-for-sample identical to an unpipelined single-rate filter.

The state holds 16 guard fraction bits below the data LSB. The output is the state rounded half-up and clipped to the data width.

Top module: `iir_dual_rate`

## Requirements
- R1: While and immediately after a synchronous reset, `y_vld` is 0, `y_out` is 0 and the internal state is zero.
- R2: For each accepted sample the state S (output scaled by 2^16) becomes S + floor(k·((x·2^16) − S) / 2^15), where k is the clamped coefficient. This is bit-exact to a single-rate model.
- R3: A strobe is accepted when `smp_stb` is high at a rising edge while no sample is in flight. `y_vld` is high for exactly one cycle, in the second cycle after the accepting edge, and carries the updated result.
- R4: A coefficient of 0x8000 (1.0) makes the output equal the input sample. Codes above 0x8000 are clamped to 1.0.
- R5: A coefficient of 0 leaves the output unchanged regardless of the input.
- R6: `y_out` is the state plus 2^15, shifted right arithmetically by 16 (round half up), clipped to the signed 16-bit range.
- R7: A strobe in the cycle right after an accepted strobe is ignored: it produces no `y_vld` and does not alter the state.
- R8: Reset asserted in mid-stream clears the state, so the next sample is filtered from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | New-sample strobe |
| smp_x | input | 16 | Signed input sample, valid with the strobe |
| coef | input | 16 | Unsigned Q1.15 smoothing coefficient |
| y_out | output | 16 | Signed filtered output |
| y_vld | output | 1 | One-cycle pulse marking an updated output |

## Verification
Random samples are fed at full rate with random coefficients, including codes above unity. These runs separate an exact two-stage recursion from one that is off by a sample or that mishandles floor rounding of negative products. Directed runs use a = 0 and a = 1.0, which separate a held output from a pure step follower. Small-step inputs at a = 0.5 land the state on an exact half LSB, which distinguishes round-half-up from truncation. Back-to-back strobes and a mid-stream reset check that the extra strobe is ignored and that the state is cleared.

// File: rtl/iir_dual_rate.sv
module iir_dual_rate #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int GW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] smp_x,
  input  logic        [CW-1:0] coef,
  output logic signed [DW-1:0] y_out,
  output logic                 y_vld
);
  localparam int SW = DW + GW;
  localparam int PW = SW + CW + 2;
  localparam logic [CW-1:0] UNITY = CW'(1) << (CW - 1);
  localparam logic signed [SW:0] HALF = (SW + 1)'(1) << (GW - 1);
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [SW-1:0] acc_q;
  logic signed [SW:0]   prod_q;
  logic                 busy_q;

  wire take = smp_stb & ~busy_q & ~rst;
  wire [CW-1:0] k = (coef > UNITY) ? UNITY : coef;

  wire signed [SW:0]   diff   = $signed({smp_x[DW-1], smp_x, {GW{1'b0}}}) - $signed({acc_q[SW-1], acc_q});
  wire signed [CW:0]   k_s    = $signed({1'b0, k});
  wire signed [PW-1:0] full   = PW'(diff) * PW'(k_s);
  wire signed [PW-1:0] scaled = full >>> (CW - 1);
  wire signed [SW+1:0] sum    = $signed({{2{acc_q[SW-1]}}, acc_q}) + $signed({prod_q[SW], prod_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      prod_q <= '0;
      busy_q <= 1'b0;
      y_vld  <= 1'b0;
    end else begin
      busy_q <= take;
      y_vld  <= busy_q;
      if (take) prod_q <= scaled[SW:0];
      if (busy_q) acc_q <= sum[SW-1:0];
    end
  end

  wire signed [SW:0] rnd = $signed({acc_q[SW-1], acc_q}) + HALF;
  wire signed [DW:0] yr  = rnd[SW:GW];
  assign y_out = (yr[DW] != yr[DW-1]) ? (yr[DW] ? YMIN : YMAX) : yr[DW-1:0];

  AST_VLD_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> ##1 y_vld); // R3
  AST_VLD_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    y_vld |-> $past(busy_q)); // R3
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q); // R7
  AST_STATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> $stable(acc_q)); // R7
  AST_UNIT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (take && coef >= UNITY) |=> ##1 (y_out == $past(smp_x, 2))); // R4
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (take && coef == '0) |=> ##1 $stable(y_out)); // R5
endmodule

// File: tb/sim_iir_dual_rate.sv
module sim_iir_dual_rate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [15:0] smp_x = '0;
  logic [15:0] coef = '0;
  logic signed [15:0] y_out;
  logic y_vld;

  int vecs = 0;
  int errs = 0;
  longint st = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iir_dual_rate u0 (.clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_x(smp_x),
                    .coef(coef), .y_out(y_out), .y_vld(y_vld));

  function automatic longint step(longint s, int x, int a);
    longint k, d;
    k = (a > 32768) ? 32768 : a;
    d = (longint'(x) <<< 16) - s;
    return s + ((k * d) >>> 15);
  endfunction

  function automatic int outv(longint s);
    longint r;
    r = (s + 32768) >>> 16;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where y_vld is high.
  task automatic send(int x, int a, string req);
    smp_stb = 1'b1; smp_x = 16'(x); coef = 16'(a);
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
    st = step(st, x, a);
    chk({req, " vld"}, int'(y_vld), 1);
    chk(req, int'(y_out), outv(st));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 vld", int'(y_vld), 0);
    chk("R1 y", int'(y_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", int'(y_vld), 0);

    send(1, 16'h4000, "R6 half up");
    chk("R6 exact", int'(y_out), 1);
    send(-4, 16'h8000, "R4 unity");
    chk("R4 follow", int'(y_out), -4);
    send(-3, 16'h4000, "R6 neg half");
    send(32767, 16'hFFFF, "R4 clamp");
    chk("R4 clamp max", int'(y_out), 32767);
    send(-32768, 16'h0000, "R5 zero");
    chk("R5 held", int'(y_out), 32767);
    send(-32768, 16'h8000, "R4 min");
    chk("R4 min exact", int'(y_out), -32768);

    // R7: strobe held into the add cycle with a different sample
    smp_stb = 1'b1; smp_x = 16'sd1000; coef = 16'h2000;
    @(negedge clk);
    smp_x = -16'sd20000; coef = 16'h8000;
    @(negedge clk);
    smp_stb = 1'b0;
    st = step(st, 1000, 16'h2000);
    chk("R7 vld", int'(y_vld), 1);
    chk("R7 value", int'(y_out), outv(st));
    @(negedge clk);
    chk("R7 no extra vld", int'(y_vld), 0);
    chk("R7 state kept", int'(y_out), outv(st));

    for (int i = 0; i < 400; i++) begin
      int x, a, sel;
      x = int'($signed(16'($urandom)));
      sel = int'($urandom % 8);
      a = (sel == 0) ? 0 : (sel == 1) ? 16'h8000 : (sel == 2) ? int'(16'($urandom) | 16'h8000)
        : int'($urandom % 16'h1000);
      send(x, a, "R2 random");
    end

    // R8: reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    st = 0;
    chk("R8 y cleared", int'(y_out), 0);
    chk("R8 vld cleared", int'(y_vld), 0);
    send(20000, 16'h1000, "R8 from zero");
    for (int i = 0; i < 40; i++) send(-12345, 16'h0800, "R2 slow step");
    for (int i = 0; i < 20; i++) send((i % 2) ? 30000 : -30000, 16'h7FFF, "R2 alt");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule